// File: doc/BRIEF.md
# CAN Controller Mode and Status Register Block

This block holds the software-visible control state of a CAN controller behind a simple 32-bit register port. Writes go through a valid/data port and reads through a registered port. The block keeps an enable bit with a self-clearing soft reset, a mode register, a set of sticky error flags, and a read-only status word. From that state it decodes one operating mode (configuration, normal, loopback, sleep or snoop) and drives it to the protocol engine. It also passes through the retransmit-disable, rate-switch-override and bus-off recovery controls.

The mode fields that shape bus behaviour can only change while the controller is disabled. The sleep request stays writable at all times and clears when the controller wakes. The start-recovery request can only be armed while the node is in bus-off. The message store, bit timing and interrupt logic are separate blocks.

Register offsets: control 0x00, mode 0x04, error flags 0x08, status 0x0C. Every other offset is unmapped.

Top module: `can_mode_regs`

## Requirements
- R1: After reset, every register reads 0 except status, which reads 0x0000_0001 (configuration bit set), and `op_mode` is 0 (configuration).
- R2: Control register: bit 1 is enable and reads back as written. Bit 0 always reads 0. Read data appears on `rd_data` in the cycle after `rd_en`.
- R3: A write to control with bit 0 set clears enable, the whole mode register and all error flags on the next edge, whatever the rest of the data is.
- R4: Mode register bits are: 0 loopback, 1 sleep, 2 snoop, 3 retransmit disable, 4 rate-switch override, 5 start recovery, 6 automatic recovery. `op_mode` codes are 0 configuration, 1 normal, 2 loopback, 3 sleep, 4 snoop. With enable 0 the code is 0. With enable 1 and none of loopback/sleep/snoop set, the code is 1. With exactly one of them set, the code is that mode.
- R5: With enable 1 and two or more of loopback/sleep/snoop set, `op_mode` is 0 and status bit 5 (illegal mode) is 1. Status bits are: 0 configuration, 1 normal, 2 loopback, 3 sleep, 4 snoop, 5 illegal, 6 live `bus_off_i`.
- R6: While enable is 1, writes to mode bits 0, 2, 3, 4 and 6 are dropped. Sleep (bit 1) in the same write still takes effect.
- R7: Start recovery (bit 5) can only be written while `bus_off_i` is 1. It clears on `recov_done_i`, and also on a control write with enable 0.
- R8: `wake_i` clears the sleep bit. It takes priority over a sleep write in the same cycle.
- R9: Error flags (bits 3:0 of 0x08) are set by the matching `err_evt` bit. A write clears only the bits written as 1, and bits written as 0 are untouched. An event in the same cycle as a clear leaves the flag set.
- R10: `wr_strb` is ignored, so the full data word is written even with all strobes 0.
- R11: A write takes effect only when `wr_addr_valid` and `wr_data_valid` are both 1.
- R12: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr_valid | input | 1 | Write address valid |
| wr_data_valid | input | 1 | Write data valid |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes (ignored) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Registered read data |
| err_evt | input | 4 | Error event pulses from the protocol engine |
| bus_off_i | input | 1 | Node is in bus-off |
| wake_i | input | 1 | Wake-up detected |
| recov_done_i | input | 1 | Bus-off recovery finished |
| op_mode | output | 3 | Decoded operating mode |
| no_retx_o | output | 1 | Retransmission disabled |
| brs_ovr_o | output | 1 | Rate-switch override |
| auto_rec_o | output | 1 | Automatic bus-off recovery |
| start_rec_o | output | 1 | Start bus-off recovery |

## Verification
The assertions assume that the protocol engine raises `recov_done_i` only while `bus_off_i` is high. The random stimulus therefore draws the recovery-done pulse only in cycles where it has already driven bus-off high. The assertions make no assumption that the two write valids arrive together: cycles with only one valid are driven on purpose, to show that such a write is dropped. Reads are issued in cycles with no write and no event pulses, so each read result can be predicted from the bench model of the previous cycle.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int ERR_W  = 4;
    localparam int MODE_W = 7;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ERR    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h0C;

    // mode fields that may only change while the controller is disabled
    localparam logic [MODE_W-1:0] PROT_MASK = 7'b101_1101;

    typedef enum logic [2:0] {
        OPM_CFG   = 3'd0,
        OPM_NORM  = 3'd1,
        OPM_LPBK  = 3'd2,
        OPM_SLEEP = 3'd3,
        OPM_SNOOP = 3'd4
    } op_mode_e;

    typedef struct packed {
        logic auto_rec;   // 6
        logic start_rec;  // 5
        logic brs_ovr;    // 4
        logic no_retx;    // 3
        logic snoop;      // 2
        logic sleep;      // 1
        logic lpbk;       // 0
    } mode_t;

    typedef struct packed {
        logic  enable;
        mode_t mode;
    } cfg_t;

endpackage

// File: rtl/cmr_cfg_regs.sv
module cmr_cfg_regs
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_mode_i,
    input  logic [MODE_W-1:0] wdata_i,
    input  logic              bus_off_i,
    input  logic              wake_i,
    input  logic              recov_done_i,
    output logic              enable_o,
    output mode_t             mode_o
);

    cfg_t cfg_d, cfg_q;
    mode_t wr_mode;

    always_comb begin
        cfg_d   = cfg_q;
        wr_mode = mode_t'(wdata_i);
        if (soft_rst_i) begin
            cfg_d = '0;
        end else begin
            if (wr_ctrl_i) begin
                cfg_d.enable = wdata_i[1];
                if (!wdata_i[1]) begin
                    cfg_d.mode.start_rec = 1'b0;
                end
            end
            if (wr_mode_i) begin
                if (!cfg_q.enable) begin
                    cfg_d.mode.lpbk     = wr_mode.lpbk;
                    cfg_d.mode.snoop    = wr_mode.snoop;
                    cfg_d.mode.no_retx  = wr_mode.no_retx;
                    cfg_d.mode.brs_ovr  = wr_mode.brs_ovr;
                    cfg_d.mode.auto_rec = wr_mode.auto_rec;
                end
                cfg_d.mode.sleep = wr_mode.sleep;
                if (bus_off_i) begin
                    cfg_d.mode.start_rec = wr_mode.start_rec;
                end
            end
            if (recov_done_i) begin
                cfg_d.mode.start_rec = 1'b0;
            end
            if (wake_i) begin
                cfg_d.mode.sleep = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_o = cfg_q.enable;
    assign mode_o   = cfg_q.mode;

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.enable && !soft_rst_i) |=> (((cfg_q.mode ^ $past(cfg_q.mode)) & PROT_MASK) == '0)); // R6
    AST_SREC_NEEDS_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q.mode.start_rec) |-> $past(bus_off_i)); // R7
    AST_DONE_IN_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done_i |-> bus_off_i); // R7
    AST_WAKE_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> !cfg_q.mode.sleep); // R8

endmodule

// File: rtl/cmr_err_flags.sv
module cmr_err_flags #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic [ERR_W-1:0] evt_i,
    input  logic             clr_en_i,
    input  logic [ERR_W-1:0] clr_mask_i,
    output logic [ERR_W-1:0] flags_o
);

    logic [ERR_W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (soft_rst_i) begin
            flags_d = '0;
        end else begin
            if (clr_en_i) begin
                flags_d = flags_d & ~clr_mask_i;
            end
            flags_d = flags_d | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en_i && !soft_rst_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt_i) && !soft_rst_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R9

endmodule

// File: rtl/cmr_mode_decode.sv
module cmr_mode_decode
    import can_mode_pkg::*;
(
    input  logic     enable_i,
    input  logic     lpbk_i,
    input  logic     sleep_i,
    input  logic     snoop_i,
    output op_mode_e mode_o,
    output logic     illegal_o
);

    logic [1:0] n_req;

    always_comb begin
        n_req = {1'b0, lpbk_i} + {1'b0, sleep_i} + {1'b0, snoop_i};
        illegal_o = 1'b0;
        mode_o    = OPM_CFG;
        if (enable_i) begin
            if (n_req > 2'd1) begin
                illegal_o = 1'b1;
            end else if (lpbk_i) begin
                mode_o = OPM_LPBK;
            end else if (sleep_i) begin
                mode_o = OPM_SLEEP;
            end else if (snoop_i) begin
                mode_o = OPM_SNOOP;
            end else begin
                mode_o = OPM_NORM;
            end
        end
    end

endmodule

// File: rtl/can_mode_regs.sv
module can_mode_regs
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_valid,
    input  logic              wr_data_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [3:0]        wr_strb,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [ERR_W-1:0]  err_evt,
    input  logic              bus_off_i,
    input  logic              wake_i,
    input  logic              recov_done_i,
    output logic [2:0]        op_mode,
    output logic              no_retx_o,
    output logic              brs_ovr_o,
    output logic              auto_rec_o,
    output logic              start_rec_o
);

    logic             wr_go, wr_ctrl, wr_mode, wr_err, soft_rst;
    logic             enable;
    mode_t            mode;
    logic [ERR_W-1:0] err_flags;
    op_mode_e         dec_mode;
    logic             illegal;
    logic [REG_W-1:0] status_word;
    logic [REG_W-1:0] rd_d, rd_q;
    logic             strb_unused;

    // strobes and upper data bits carry no meaning here
    assign strb_unused = ^{wr_strb, wr_data[REG_W-1:MODE_W]};

    assign wr_go    = wr_addr_valid && wr_data_valid;
    assign wr_ctrl  = wr_go && (wr_addr == OFF_CTRL);
    assign wr_mode  = wr_go && (wr_addr == OFF_MODE);
    assign wr_err   = wr_go && (wr_addr == OFF_ERR);
    assign soft_rst = wr_ctrl && wr_data[0];

    cmr_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst),
        .wr_ctrl_i    (wr_ctrl),
        .wr_mode_i    (wr_mode),
        .wdata_i      (wr_data[MODE_W-1:0]),
        .bus_off_i    (bus_off_i),
        .wake_i       (wake_i),
        .recov_done_i (recov_done_i),
        .enable_o     (enable),
        .mode_o       (mode)
    );

    cmr_err_flags #(.ERR_W(ERR_W)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .evt_i      (err_evt),
        .clr_en_i   (wr_err),
        .clr_mask_i (wr_data[ERR_W-1:0]),
        .flags_o    (err_flags)
    );

    cmr_mode_decode u_dec (
        .enable_i  (enable),
        .lpbk_i    (mode.lpbk),
        .sleep_i   (mode.sleep),
        .snoop_i   (mode.snoop),
        .mode_o    (dec_mode),
        .illegal_o (illegal)
    );

    always_comb begin
        status_word    = '0;
        status_word[0] = (dec_mode == OPM_CFG);
        status_word[1] = (dec_mode == OPM_NORM);
        status_word[2] = (dec_mode == OPM_LPBK);
        status_word[3] = (dec_mode == OPM_SLEEP);
        status_word[4] = (dec_mode == OPM_SNOOP);
        status_word[5] = illegal;
        status_word[6] = bus_off_i;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            unique case (rd_addr)
                OFF_CTRL:   rd_d = {{(REG_W-2){1'b0}}, enable, 1'b0};
                OFF_MODE:   rd_d = {{(REG_W-MODE_W){1'b0}}, mode};
                OFF_ERR:    rd_d = {{(REG_W-ERR_W){1'b0}}, err_flags};
                OFF_STATUS: rd_d = status_word;
                default:    rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data     = rd_q;
    assign op_mode     = dec_mode;
    assign no_retx_o   = mode.no_retx;
    assign brs_ovr_o   = mode.brs_ovr;
    assign auto_rec_o  = mode.auto_rec;
    assign start_rec_o = mode.start_rec;

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(status_word[4:0])); // R4
    AST_DISABLED_IS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (op_mode == 3'd0)); // R4
    AST_ILLEGAL_IS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (op_mode == 3'd0 && enable)); // R5
    AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!enable && mode == '0 && err_flags == '0)); // R3
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != OFF_CTRL && rd_addr != OFF_MODE && rd_addr != OFF_ERR
         && rd_addr != OFF_STATUS) |=> (rd_data == '0)); // R12

endmodule

// File: tb/test_can_mode_regs.sv
module test_can_mode_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_addr_valid = 1'b0, wr_data_valid = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  err_evt = '0;
    logic        bus_off_i = 1'b0, wake_i = 1'b0, recov_done_i = 1'b0;
    logic [2:0]  op_mode;
    logic        no_retx_o, brs_ovr_o, auto_rec_o, start_rec_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model
    logic       m_en = 1'b0;
    logic [6:0] m_mode = '0;
    logic [3:0] m_err = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mode_regs i_can_mode_regs (
        .clk, .rst_n, .wr_addr_valid, .wr_data_valid, .wr_addr, .wr_data, .wr_strb,
        .rd_en, .rd_addr, .rd_data, .err_evt, .bus_off_i, .wake_i, .recov_done_i,
        .op_mode, .no_retx_o, .brs_ovr_o, .auto_rec_o, .start_rec_o
    );

    function automatic logic [2:0] exp_code();
        int n;
        n = int'(m_mode[0]) + int'(m_mode[1]) + int'(m_mode[2]);
        if (!m_en || n > 1) return 3'd0;
        if (m_mode[0]) return 3'd2;
        if (m_mode[1]) return 3'd3;
        if (m_mode[2]) return 3'd4;
        return 3'd1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] s;
        logic [2:0] c;
        int n;
        case (a)
            8'h00: return {30'b0, m_en, 1'b0};
            8'h04: return {25'b0, m_mode};
            8'h08: return {28'b0, m_err};
            8'h0C: begin
                c = exp_code();
                n = int'(m_mode[0]) + int'(m_mode[1]) + int'(m_mode[2]);
                s = '0;
                s[0] = (c == 3'd0);
                s[1] = (c == 3'd1);
                s[2] = (c == 3'd2);
                s[3] = (c == 3'd3);
                s[4] = (c == 3'd4);
                s[5] = m_en && (n > 1);
                s[6] = bus_off_i;
                return s;
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one drive cycle; starts and ends just after a falling edge
    task automatic cyc(input logic awv, input logic wv, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] s, input logic [3:0] ev,
                       input logic bo, input logic wk, input logic dn);
        logic       n_en;
        logic [6:0] n_mode;
        logic [3:0] n_err, clr;
        logic       go;
        wr_addr_valid = awv; wr_data_valid = wv; wr_addr = a; wr_data = d; wr_strb = s;
        err_evt = ev; bus_off_i = bo; wake_i = wk; recov_done_i = dn;
        go = awv && wv;
        n_en = m_en; n_mode = m_mode;
        clr = (go && a == 8'h08) ? d[3:0] : 4'h0;
        n_err = (m_err & ~clr) | ev;
        if (go && a == 8'h00 && d[0]) begin
            n_en = 1'b0; n_mode = '0; n_err = '0;
        end else begin
            if (go && a == 8'h00) begin
                n_en = d[1];
                if (!d[1]) n_mode[5] = 1'b0;
            end
            if (go && a == 8'h04) begin
                if (!m_en) begin
                    n_mode[0] = d[0]; n_mode[2] = d[2]; n_mode[3] = d[3];
                    n_mode[4] = d[4]; n_mode[6] = d[6];
                end
                n_mode[1] = d[1];
                if (bo) n_mode[5] = d[5];
            end
            if (dn) n_mode[5] = 1'b0;
            if (wk) n_mode[1] = 1'b0;
        end
        @(posedge clk);
        m_en = n_en; m_mode = n_mode; m_err = n_err;
        @(negedge clk);
        wr_addr_valid = 0; wr_data_valid = 0; err_evt = '0; wake_i = 0; recov_done_i = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 4'hF, 4'h0, bus_off_i, 0, 0);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] e;
        rd_en = 1; rd_addr = a;
        e = exp_read(a);
        @(posedge clk);
        @(negedge clk);
        rd_en = 0;
        check(tag, rd_data, e);
    endtask

    task automatic mode_chk(input string tag);
        check(tag, {29'b0, op_mode}, {29'b0, exp_code()});
        check(tag, {28'b0, no_retx_o, brs_ovr_o, auto_rec_o, start_rec_o},
              {28'b0, m_mode[3], m_mode[4], m_mode[6], m_mode[5]});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        logic [31:0] d;
        logic bo, dn;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 op_mode", {29'b0, op_mode}, 32'd0);
        rd_chk(8'h00, "R1 ctrl");
        rd_chk(8'h04, "R1 mode");
        rd_chk(8'h08, "R1 err");
        rd_chk(8'h0C, "R1 status");
        check("R1 status literal", rd_data, 32'h1);

        // R2 enable readback, reset bit reads 0
        wr(8'h00, 32'h2);
        rd_chk(8'h00, "R2 ctrl");
        check("R2 literal", rd_data, 32'h2);
        check("R4 normal", {29'b0, op_mode}, 32'd1);

        // R6 protected fields dropped, sleep still written
        wr(8'h04, 32'h5F);
        rd_chk(8'h04, "R6 mode");
        check("R6 literal", rd_data, 32'h02);
        check("R4 sleep", {29'b0, op_mode}, 32'd3);

        // R8 wake wins over a sleep write
        cyc(1, 1, 8'h04, 32'h2, 4'hF, 0, 0, 1, 0);
        rd_chk(8'h04, "R8 wake");
        check("R8 literal", rd_data, 32'h0);

        // R4 snoop, R5 illegal combination
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h04);
        wr(8'h00, 32'h2);
        check("R4 snoop", {29'b0, op_mode}, 32'd4);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h05);
        wr(8'h00, 32'h2);
        mode_chk("R5 mode");
        rd_chk(8'h0C, "R5 status");
        check("R5 literal", rd_data, 32'h21);

        // R7 start recovery gated by bus-off
        wr(8'h04, 32'h20);
        rd_chk(8'h04, "R7 no busoff");
        cyc(1, 1, 8'h04, 32'h20, 4'hF, 0, 1, 0, 0);
        check("R7 armed", {31'b0, start_rec_o}, 32'd1);
        cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, 1);
        check("R7 done", {31'b0, start_rec_o}, 32'd0);
        cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0);

        // R9 flags
        cyc(0, 0, 8'h00, 0, 0, 4'hB, 0, 0, 0);
        wr(8'h08, 32'h0);
        rd_chk(8'h08, "R9 write zero");
        check("R9 literal", rd_data, 32'hB);
        cyc(1, 1, 8'h08, 32'h3, 4'hF, 4'h1, 0, 0, 0);
        rd_chk(8'h08, "R9 set wins");
        check("R9 literal2", rd_data, 32'h9);

        // R10 strobes ignored, R11 partial valid dropped
        wr(8'h00, 32'h0);
        cyc(1, 1, 8'h04, 32'h18, 4'h0, 0, 0, 0, 0);
        rd_chk(8'h04, "R10 strobe");
        check("R10 literal", rd_data, 32'h18);
        cyc(1, 0, 8'h00, 32'h2, 4'hF, 0, 0, 0, 0);
        cyc(0, 1, 8'h00, 32'h2, 4'hF, 0, 0, 0, 0);
        rd_chk(8'h00, "R11 partial");
        check("R11 literal", rd_data, 32'h0);

        // R12 unmapped
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, "R12 read");
        rd_chk(8'h04, "R12 mode intact");

        // R3 soft reset
        wr(8'h00, 32'h2);
        cyc(0, 0, 8'h00, 0, 0, 4'hF, 0, 0, 0);
        wr(8'h00, 32'h3);
        rd_chk(8'h00, "R3 ctrl");
        rd_chk(8'h04, "R3 mode");
        rd_chk(8'h08, "R3 err");
        check("R3 literal", rd_data, 32'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            a = 8'($urandom_range(0, 7) * 4);
            d = $urandom;
            if (a == 8'h00 && $urandom_range(0, 9) != 0) d[0] = 1'b0;
            bo = ($urandom_range(0, 3) == 0);
            dn = bo && ($urandom_range(0, 4) == 0);
            cyc($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0, a, d, 4'($urandom),
                ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0, bo,
                $urandom_range(0, 19) == 0, dn);
            mode_chk("R4 random mode");
            a = 8'($urandom_range(0, 7) * 4);
            case (a)
                8'h00:   rd_chk(a, "R2 random");
                8'h04:   rd_chk(a, "R6 random");
                8'h08:   rd_chk(a, "R9 random");
                8'h0C:   rd_chk(a, "R5 random");
                default: rd_chk(a, "R12 random");
            endcase
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule